// File: doc/BRIEF.md
# Two-Mode 8x8 Multiply Execution Unit

This unit is the multiply stage of a small 8-bit processor core. When a start strobe arrives, it looks at a 16-bit instruction word and recognises two multiply encodings. One multiplies two signed bytes. The other multiplies a signed byte by an unsigned byte. For either form it sends two register addresses to a read port of the register file and captures the bytes that come back.

It forms the 16-bit product during the following cycle. In the cycle after that, it pulses the write enables for the fixed destination pair: the high byte goes to register 1 and the low byte to register 0. In that same cycle it also pulses a status update that carries only the carry and zero flags. All other status flags belong to the core and the unit never touches them.

An instruction word that matches neither encoding is reported on an illegal-operation pulse and causes no writes.

Top module: `mul_exec_unit`

## Requirements
- R1: When insn_i[15:8] is 0x02 (both-signed form), src_a_addr_o is 16 plus insn_i[7:4] and src_b_addr_o is 16 plus insn_i[3:0], so both addresses lie in 16..31.
- R2: When insn_i[15:8] is 0x03 and insn_i[7] and insn_i[3] are both 0 (mixed form), src_a_addr_o is 16 plus insn_i[6:4] and src_b_addr_o is 16 plus insn_i[2:0], so both addresses lie in 16..23.
- R3: In the both-signed form, {res_hi_o,res_lo_o} equals the two's-complement product of the two source bytes, both taken as signed.
- R4: In the mixed form, the first source byte is taken as signed and the second as unsigned, and {res_hi_o,res_lo_o} is the low 16 bits of the signed product.
- R5: wr_hi_en_o (register 1, high byte) and wr_lo_en_o (register 0, low byte) pulse together for exactly one cycle, whatever the source registers are.
- R6: When flag_we_o is high, flag_c_o equals bit 15 of the product.
- R7: When flag_we_o is high, flag_z_o is 1 exactly when the full 16-bit product is 0x0000.
- R8: A legal start gives busy_o high for the one cycle after the start edge, then done_o, both write enables and flag_we_o high together for the next cycle only.
- R9: A word that matches neither form gives illegal_o high for the one cycle after the start edge, with no busy_o, done_o, write enable or flag_we_o.
- R10: A start presented while busy_o is high is ignored: the running result is unaffected and no second operation follows.
- R11: After reset, busy_o, done_o, illegal_o, all write enables and flag_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for insn_i |
| insn_i | input | 16 | Instruction word |
| src_a_addr_o | output | 5 | Read address of the multiplicand register |
| src_b_addr_o | output | 5 | Read address of the multiplier register |
| src_a_data_i | input | 8 | Multiplicand byte from the register file |
| src_b_data_i | input | 8 | Multiplier byte from the register file |
| busy_o | output | 1 | Product being formed |
| done_o | output | 1 | Result cycle |
| illegal_o | output | 1 | Unrecognised instruction word |
| wr_hi_en_o | output | 1 | Write enable for register 1 |
| wr_lo_en_o | output | 1 | Write enable for register 0 |
| res_hi_o | output | 8 | Product bits 15:8 |
| res_lo_o | output | 8 | Product bits 7:0 |
| flag_we_o | output | 1 | Carry and zero update strobe |
| flag_c_o | output | 1 | New carry flag |
| flag_z_o | output | 1 | New zero flag |

## Verification
Each form is driven with operand pairs chosen so that a wrong signedness choice shows up in the result. Positive-by-positive pairs give the same answer under every interpretation, so they confirm the datapath and nothing more. Negative multiplicands and multipliers of 0x80 or above separate signed from unsigned handling of each operand. The pair -128 by -128 exposes a missing top partial-product term. Zero operands exercise the zero flag, and the highest and lowest register numbers of each form exercise field decoding. Words that are off by a single reserved bit separate the mixed form from illegal words.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_SS   = 2'd1,
        MODE_SU   = 2'd2
    } mul_mode_e;
endpackage

// File: rtl/mulu_decode.sv
module mulu_decode
    import mulu_pkg::*;
#(
    parameter int INSN_W = 16,
    parameter int AW     = 5
) (
    input  logic [INSN_W-1:0] insn,
    output mul_mode_e         mode,
    output logic [AW-1:0]     addr_a,
    output logic [AW-1:0]     addr_b
);
    localparam logic [7:0] OPC_SS = 8'h02;
    localparam logic [7:0] OPC_SU = 8'h03;

    always_comb begin
        mode   = MODE_NONE;
        addr_a = '0;
        addr_b = '0;
        if (insn[15:8] == OPC_SS) begin
            mode   = MODE_SS;
            addr_a = {1'b1, insn[7:4]};
            addr_b = {1'b1, insn[3:0]};
        end else if (insn[15:8] == OPC_SU && !insn[7] && !insn[3]) begin
            mode   = MODE_SU;
            addr_a = {2'b10, insn[6:4]};
            addr_b = {2'b10, insn[2:0]};
        end
    end
endmodule

// File: rtl/mulu_core.sv
module mulu_core #(
    parameter int W         = 8,
    parameter int SHIFT_ADD = 1
) (
    input  logic          su,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [W:0] b_x;
    assign b_x = {(su ? 1'b0 : b[W-1]), b};

    generate
        if (SHIFT_ADD != 0) begin : g_shift_add
            logic [PW-1:0] a_ext;
            logic [PW-1:0] acc [0:W+1];
            assign a_ext  = {{W{a[W-1]}}, a};
            assign acc[0] = '0;
            for (genvar i = 0; i <= W; i++) begin : g_pp
                logic [PW-1:0] term;
                assign term = b_x[i] ? (a_ext << i) : '0;
                if (i == W) begin : g_neg
                    assign acc[i+1] = acc[i] - term;
                end else begin : g_pos
                    assign acc[i+1] = acc[i] + term;
                end
            end
            assign prod = acc[W+1];
        end else begin : g_operator
            logic signed [PW-1:0] full;
            assign full = $signed({a[W-1], a}) * $signed(b_x);
            assign prod = full;
        end
    endgenerate
endmodule

// File: rtl/mulu_flags.sv
module mulu_flags #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] prod,
    output logic          carry,
    output logic          zero
);
    assign carry = prod[PW-1];
    assign zero  = (prod == '0);
endmodule

// File: rtl/mul_exec_unit.sv
module mul_exec_unit
    import mulu_pkg::*;
#(
    parameter int W         = 8,
    parameter int INSN_W    = 16,
    parameter int AW        = 5,
    parameter int SHIFT_ADD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic [AW-1:0]     src_a_addr_o,
    output logic [AW-1:0]     src_b_addr_o,
    input  logic [W-1:0]      src_a_data_i,
    input  logic [W-1:0]      src_b_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic              wr_hi_en_o,
    output logic              wr_lo_en_o,
    output logic [W-1:0]      res_hi_o,
    output logic [W-1:0]      res_lo_o,
    output logic              flag_we_o,
    output logic              flag_c_o,
    output logic              flag_z_o
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic          busy;
        logic          su;
        logic [W-1:0]  opa;
        logic [W-1:0]  opb;
        logic [PW-1:0] prod;
        logic          done;
        logic          bad;
        logic          c;
        logic          z;
    } unit_st_t;

    unit_st_t  st_d, st_q;
    mul_mode_e mode;
    logic [PW-1:0] prod_w;
    logic carry_w, zero_w;

    mulu_decode #(.INSN_W(INSN_W), .AW(AW)) u_dec (
        .insn   (insn_i),
        .mode   (mode),
        .addr_a (src_a_addr_o),
        .addr_b (src_b_addr_o)
    );

    mulu_core #(.W(W), .SHIFT_ADD(SHIFT_ADD)) u_core (
        .su   (st_q.su),
        .a    (st_q.opa),
        .b    (st_q.opb),
        .prod (prod_w)
    );

    mulu_flags #(.PW(PW)) u_flags (
        .prod  (prod_w),
        .carry (carry_w),
        .zero  (zero_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.bad  = 1'b0;
        if (st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.prod = prod_w;
            st_d.c    = carry_w;
            st_d.z    = zero_w;
        end else if (start_i) begin
            if (mode == MODE_NONE) begin
                st_d.bad = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.su   = (mode == MODE_SU);
                st_d.opa  = src_a_data_i;
                st_d.opb  = src_b_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o     = st_q.busy;
    assign done_o     = st_q.done;
    assign illegal_o  = st_q.bad;
    assign wr_hi_en_o = st_q.done;
    assign wr_lo_en_o = st_q.done;
    assign flag_we_o  = st_q.done;
    assign res_hi_o   = st_q.prod[PW-1:W];
    assign res_lo_o   = st_q.prod[W-1:0];
    assign flag_c_o   = st_q.c;
    assign flag_z_o   = st_q.z;

    p_ss_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SS) |-> src_a_addr_o[AW-1] && src_b_addr_o[AW-1]);
    p_su_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SU) |-> (src_a_addr_o[AW-1:3] == 2'b10) && (src_b_addr_o[AW-1:3] == 2'b10));
    p_done_follows_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> done_o && !busy_o);
    p_done_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));
    p_pair_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_en_o == wr_lo_en_o);
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> flag_c_o == res_hi_o[W-1]);
    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> flag_z_o == ({res_hi_o, res_lo_o} == '0));
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !busy_o && !done_o && !wr_hi_en_o && !flag_we_o);
    p_illegal_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $past(start_i) && !$past(busy_o));
    p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(busy_o) || done_o);
endmodule

// File: tb/sim_mul_exec_unit.sv
module sim_mul_exec_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] insn = '0;
    logic [4:0] a_addr, b_addr;
    logic [7:0] a_data, b_data;
    logic busy, done, illegal, we_hi, we_lo, fwe, fc, fz;
    logic [7:0] rhi, rlo;
    logic [7:0] rf [0:31];
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign a_data = rf[a_addr];
    assign b_data = rf[b_addr];

    mul_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .insn_i(insn),
        .src_a_addr_o(a_addr), .src_b_addr_o(b_addr),
        .src_a_data_i(a_data), .src_b_data_i(b_data),
        .busy_o(busy), .done_o(done), .illegal_o(illegal),
        .wr_hi_en_o(we_hi), .wr_lo_en_o(we_lo),
        .res_hi_o(rhi), .res_lo_o(rlo),
        .flag_we_o(fwe), .flag_c_o(fc), .flag_z_o(fz)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input bit su, input logic [7:0] a, input logic [7:0] b);
        int av, bv, p;
        av = int'($signed(a));
        bv = su ? int'(b) : int'($signed(b));
        p  = av * bv;
        return p[15:0];
    endfunction

    task automatic do_mul(input bit su, input int d, input int r,
                          input logic [7:0] a, input logic [7:0] b, input string tag);
        logic [15:0] exp;
        logic [15:0] got;
        rf[16 + d] = a;
        rf[16 + r] = b;
        exp = model(su, a, b);
        @(negedge clk);
        insn  = su ? {8'h03, 1'b0, 3'(d), 1'b0, 3'(r)} : {8'h02, 4'(d), 4'(r)};
        start = 1'b1;
        #0;
        check(a_addr == 5'(16 + d), {tag, " R1/R2 addr a"}, a_addr, 16 + d);
        check(b_addr == 5'(16 + r), {tag, " R1/R2 addr b"}, b_addr, 16 + r);
        @(negedge clk);
        start = 1'b0;
        check(busy && !done && !we_hi, {tag, " R8 busy cycle"}, {busy, done, we_hi}, 3'b100);
        @(negedge clk);
        got = {rhi, rlo};
        check(done && fwe && !busy, {tag, " R8 done cycle"}, {done, fwe, busy}, 3'b110);
        check(we_hi && we_lo, {tag, " R5 write pair"}, {we_hi, we_lo}, 2'b11);
        check(got == exp, {tag, su ? " R4 product" : " R3 product"}, got, exp);
        check(fc == exp[15], {tag, " R6 carry"}, fc, exp[15]);
        check(fz == (exp == 16'h0), {tag, " R7 zero"}, fz, exp == 16'h0);
        @(negedge clk);
        check(!done && !we_hi && !we_lo && !fwe, {tag, " R5 single pulse"}, {done, we_hi, we_lo, fwe}, 0);
    endtask

    task automatic do_illegal(input logic [15:0] w);
        @(negedge clk);
        insn  = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(illegal && !busy, "R9 illegal flagged", {illegal, busy}, 2'b10);
        @(negedge clk);
        check(!illegal && !done && !we_hi && !we_lo && !fwe && !busy,
              "R9 no writes", {illegal, done, we_hi, we_lo, fwe, busy}, 0);
    endtask

    task automatic do_busy_ignore();
        logic [15:0] exp;
        rf[18] = 8'hF6;
        rf[19] = 8'h07;
        rf[20] = 8'h00;
        exp = model(1'b0, 8'hF6, 8'h07);
        @(negedge clk);
        insn  = 16'h0223;
        start = 1'b1;
        @(negedge clk);
        insn  = 16'h0244;
        check(busy, "R10 busy", busy, 1);
        @(negedge clk);
        start = 1'b0;
        check(done && {rhi, rlo} == exp, "R10 first result kept", {rhi, rlo}, exp);
        @(negedge clk);
        check(!busy && !done, "R10 no second op", {busy, done}, 0);
        @(negedge clk);
        check(!done, "R10 no late done", done, 0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 8'(i * 7);
        repeat (3) @(negedge clk);
        check(!busy && !done && !illegal && !we_hi && !we_lo && !fwe, "R11 reset state",
              {busy, done, illegal, we_hi, we_lo, fwe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_mul(1'b0, 1, 2, 8'd12, 8'd10, "ss pos");
        do_mul(1'b0, 15, 0, 8'hFD, 8'd40, "ss neg-pos");
        do_mul(1'b0, 3, 4, 8'h80, 8'h80, "ss min-min");
        do_mul(1'b0, 5, 6, 8'h80, 8'h7F, "ss min-max");
        do_mul(1'b0, 0, 15, 8'h00, 8'hC3, "ss zero");
        do_mul(1'b0, 7, 8, 8'hFF, 8'hFF, "ss m1-m1");
        do_mul(1'b1, 0, 7, 8'hFF, 8'hFF, "su m1-255");
        do_mul(1'b1, 1, 2, 8'h80, 8'hFF, "su min-255");
        do_mul(1'b1, 7, 0, 8'h7F, 8'hFF, "su max-255");
        do_mul(1'b1, 3, 5, 8'd9, 8'd0, "su zero");
        do_mul(1'b1, 4, 6, 8'hF0, 8'h90, "su neg-high");
        do_illegal(16'h0000);
        do_illegal(16'h0380);
        do_illegal(16'h0308);
        do_illegal(16'h0412);
        do_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule